// File: doc/BRIEF.md
# Hot-Swap Gate Control Sequencer

This block is the digital part of a live-insertion power switch. Comparators outside the block digitise the supply, current and gate/drain conditions. From those flags the block decides when the external pass transistor may conduct. The gate stays off until the supply is within its window and the hot-side manual reset is released. After a fixed power-on wait, the gate is enabled.

While the gate is on, an overcurrent indication is deglitched over a window picked by a 2-bit code. A confirmed fault shuts the gate off. After a retry pause picked by a second 2-bit code, the gate is enabled again. Until the load reports power good, the block selects the insertion overcurrent threshold. Power good needs both the drain-good and gate-high indications. If a run of consecutive trips never reaches power good, the block latches a retry-failure flag and stays off until the supply or the manual reset disqualifies it.

All intervals count a clock-enable tick of `TICK_DIV` clocks. Integrators set the tick to one microsecond, and a bench can scale every count down.

Top module: `hsw_gate_seq`

## Requirements
- R1: While `uv_flag`, `ov_flag` or `man_rst` is high, `gate_on` is low from the next clock onward. This holds in every state.
- R2: Once all three disqualifiers are low, `gate_on` rises after `POR_TICKS` ticks plus at most two clocks. One tick is `TICK_DIV` clocks. Releasing `man_rst` restarts this wait from zero.
- R3: With the gate on, `oc_flag` trips the gate off only if it stays high for a window set by `filt_code`. Code 0 means no filter. Codes 1, 2 and 3 mean 1, 2 and 4 times `FILT_UNIT_TICKS` ticks. A shorter pulse leaves the gate on.
- R4: After an overcurrent trip, the gate turns on again once a pause set by `retry_code` has passed. Codes 0, 1, 2 and 3 mean 1, 5, 10 and 50 times `RETRY_UNIT_TICKS` ticks.
- R5: `ins_thresh_sel` is high, selecting the insertion threshold, whenever `pgood` is low. It is low whenever `pgood` is high.
- R6: `pgood` is the registered AND of the gate being on, `drain_good` and `gate_high`. It falls one clock after either indication drops.
- R7: Suppose `MAX_RETRIES`+1 consecutive overcurrent trips occur with no `pgood` in between. Then `retry_fail` rises and the gate stays off for as long as no disqualifier appears.
- R8: A disqualifier clears `retry_fail` and the trip count. The next turn-on then goes through the full R2 wait.
- R9: In reset, `gate_on`, `pgood` and `retry_fail` are low and `ins_thresh_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_flag | input | 1 | Supply below undervoltage threshold |
| ov_flag | input | 1 | Supply above overvoltage threshold |
| oc_flag | input | 1 | Sense voltage above selected overcurrent threshold |
| drain_good | input | 1 | Drain voltage indicates load charged |
| gate_high | input | 1 | Gate voltage indicates switch fully on |
| man_rst | input | 1 | Hot-side manual reset, high holds gate off |
| filt_code | input | 2 | Overcurrent deglitch window select |
| retry_code | input | 2 | Retry pause select |
| gate_on | output | 1 | Gate enable to the slew-limited driver |
| pgood | output | 1 | Power good |
| ins_thresh_sel | output | 1 | High selects insertion overcurrent threshold |
| retry_fail | output | 1 | Retries after hard short did not succeed |

## Verification
The bench builds the block with `TICK_DIV`=2, `POR_TICKS`=20, `FILT_UNIT_TICKS`=2, `RETRY_UNIT_TICKS`=3 and `MAX_RETRIES`=3. With these values the power-on wait takes about 40 clocks. The longest deglitch window is 16 clocks, and even the 50-unit retry pause stays near 300 clocks. Every code of both selects and the full trip-to-lockout run therefore fit in a short run. A divider of 2 keeps tick phase uncertainty visible, so each timing check uses bounds on both sides of the tick edge.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POR,
      ST_ON,
      ST_RETRY,
      ST_LOCK
   } hsw_state_e;

   // deglitch window multiplier of the filter unit
   function automatic int filt_mult(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 1;
         2'd2:    return 2;
         default: return 4;
      endcase
   endfunction

   // retry pause multiplier of the retry unit
   function automatic int retry_mult(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 5;
         2'd2:    return 10;
         default: return 50;
      endcase
   endfunction

endpackage

// File: rtl/hsw_tick_gen.sv
module hsw_tick_gen #(
   parameter int TICK_DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/hsw_oc_filter.sv
module hsw_oc_filter
   import hsw_pkg::*;
#(
   parameter int FILT_UNIT_TICKS = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       arm,
   input  logic       oc_in,
   input  logic [1:0] code,
   output logic       fault
);
   localparam int FW = $clog2(4 * FILT_UNIT_TICKS + 1);

   generate
      if (FILT_UNIT_TICKS < 1) begin : g_bad_unit
         $error("FILT_UNIT_TICKS must be at least 1");
      end
   endgenerate

   logic [FW-1:0] win;
   logic [FW-1:0] cnt;

   assign win = FW'(filt_mult(code) * FILT_UNIT_TICKS);

   always_ff @(posedge clk) begin
      if (!rst_n || !arm || !oc_in) begin
         cnt   <= '0;
         fault <= 1'b0;
      end else begin
         if (tick && (cnt < win)) cnt <= cnt + 1'b1;
         fault <= (win == '0) || (cnt >= win);
      end
   end
endmodule

// File: rtl/hsw_interval_timer.sv
module hsw_interval_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (tick && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0) && !load;
endmodule

// File: rtl/hsw_gate_seq.sv
module hsw_gate_seq
   import hsw_pkg::*;
#(
   parameter int TICK_DIV         = 100,
   parameter int POR_TICKS        = 50000,
   parameter int FILT_UNIT_TICKS  = 5,
   parameter int RETRY_UNIT_TICKS = 100000,
   parameter int MAX_RETRIES      = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uv_flag,
   input  logic       ov_flag,
   input  logic       oc_flag,
   input  logic       drain_good,
   input  logic       gate_high,
   input  logic       man_rst,
   input  logic [1:0] filt_code,
   input  logic [1:0] retry_code,
   output logic       gate_on,
   output logic       pgood,
   output logic       ins_thresh_sel,
   output logic       retry_fail
);
   localparam int RETRY_LONGEST = RETRY_UNIT_TICKS * 50;
   localparam int TMAX = (POR_TICKS > RETRY_LONGEST) ? POR_TICKS : RETRY_LONGEST;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int CW   = $clog2(MAX_RETRIES + 2);
   localparam logic [CW-1:0] TRIP_LIMIT = CW'(MAX_RETRIES);

   generate
      if (POR_TICKS < 1 || RETRY_UNIT_TICKS < 1) begin : g_bad_time
         $error("POR_TICKS and RETRY_UNIT_TICKS must be at least 1");
      end
      if (MAX_RETRIES < 0) begin : g_bad_retry
         $error("MAX_RETRIES must not be negative");
      end
   endgenerate

   hsw_state_e    state, state_nx;
   logic          tick, fault, tmr_done, tmr_load;
   logic [TW-1:0] tmr_val;
   logic [CW-1:0] trips;
   logic          disq;

   hsw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   hsw_oc_filter #(.FILT_UNIT_TICKS(FILT_UNIT_TICKS)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .arm(state == ST_ON),
      .oc_in(oc_flag), .code(filt_code), .fault(fault)
   );

   hsw_interval_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmr_load),
      .load_val(tmr_val), .done(tmr_done)
   );

   assign disq = uv_flag | ov_flag | man_rst;

   always_comb begin
      state_nx = state;
      tmr_load = 1'b0;
      tmr_val  = TW'(POR_TICKS);
      if (disq) begin
         state_nx = ST_IDLE;
      end else begin
         case (state)
            ST_IDLE: begin
               state_nx = ST_POR;
               tmr_load = 1'b1;
            end
            ST_POR:   if (tmr_done) state_nx = ST_ON;
            ST_ON: if (fault) begin
               if (trips == TRIP_LIMIT) begin
                  state_nx = ST_LOCK;
               end else begin
                  state_nx = ST_RETRY;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(retry_mult(retry_code) * RETRY_UNIT_TICKS);
               end
            end
            ST_RETRY: if (tmr_done) state_nx = ST_ON;
            default:  state_nx = ST_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         trips <= '0;
         pgood <= 1'b0;
      end else begin
         state <= state_nx;
         pgood <= (state == ST_ON) && drain_good && gate_high;
         if (disq || pgood)
            trips <= '0;
         else if (state == ST_ON && fault && trips != TRIP_LIMIT)
            trips <= trips + 1'b1;
      end
   end

   assign gate_on        = (state == ST_ON);
   assign retry_fail     = (state == ST_LOCK);
   assign ins_thresh_sel = !pgood;
endmodule

// File: rtl/hsw_gate_seq_chk.sv
module hsw_gate_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic uv_flag,
   input logic ov_flag,
   input logic man_rst,
   input logic drain_good,
   input logic gate_high,
   input logic gate_on,
   input logic pgood,
   input logic ins_thresh_sel,
   input logic retry_fail
);
   AST_DISQUAL_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_flag || ov_flag || man_rst) |=> !gate_on); // R1
   AST_GATE_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_on) |-> $past(!uv_flag && !ov_flag && !man_rst)); // R2
   AST_PGOOD_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> $past(drain_good && gate_high && gate_on)); // R6
   AST_INS_THRESH_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_on |=> ins_thresh_sel); // R5
   AST_FAIL_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      retry_fail |-> !gate_on); // R7
   AST_FAIL_FROM_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(retry_fail) |-> $past(gate_on)); // R7
   AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_flag || ov_flag || man_rst) |=> !retry_fail); // R8
endmodule

bind hsw_gate_seq hsw_gate_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ov_flag(ov_flag),
   .man_rst(man_rst), .drain_good(drain_good), .gate_high(gate_high),
   .gate_on(gate_on), .pgood(pgood), .ins_thresh_sel(ins_thresh_sel),
   .retry_fail(retry_fail)
);

// File: tb/hsw_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hsw_gate_seq_tb_top;
   localparam int D  = 2;
   localparam int P  = 20;
   localparam int FU = 2;
   localparam int RU = 3;
   localparam int MR = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv = 1'b0, ov = 1'b0, oc = 1'b0, dg = 1'b0, gh = 1'b0, mrh = 1'b0;
   logic [1:0] fcode = 2'd0, rcode = 2'd0;
   logic gate_on, pgood, sel, fail;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   hsw_gate_seq #(.TICK_DIV(D), .POR_TICKS(P), .FILT_UNIT_TICKS(FU),
                  .RETRY_UNIT_TICKS(RU), .MAX_RETRIES(MR)) dut_i (
      .clk(clk), .rst_n(rst_n), .uv_flag(uv), .ov_flag(ov), .oc_flag(oc),
      .drain_good(dg), .gate_high(gh), .man_rst(mrh), .filt_code(fcode),
      .retry_code(rcode), .gate_on(gate_on), .pgood(pgood),
      .ins_thresh_sel(sel), .retry_fail(fail)
   );

   function automatic int win_ticks(input logic [1:0] c);
      case (c) 2'd0: return 0; 2'd1: return FU; 2'd2: return 2*FU; default: return 4*FU; endcase
   endfunction

   function automatic int retry_ticks(input logic [1:0] c);
      case (c) 2'd0: return RU; 2'd1: return 5*RU; 2'd2: return 10*RU; default: return 50*RU; endcase
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // after disqualifiers are released at this negedge, gate follows the wait
   task automatic qual_wait(input string req);
      step((P-1)*D);
      chk({req, " gate off during wait"}, gate_on, 1'b0);
      step(D + 4);
      chk({req, " gate on after wait"}, gate_on, 1'b1);
   endtask

   task automatic requal();
      uv = 1'b1; step(1); uv = 1'b0;
      qual_wait("R8");
   endtask

   task automatic wait_fall(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (!gate_on) begin ok = 1'b1; break; end
         step(1);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      bit ok;
      void'($urandom(32'd1234));
      step(5);
      chk("R9 gate", gate_on, 1'b0);
      chk("R9 pgood", pgood, 1'b0);
      chk("R9 sel", sel, 1'b1);
      chk("R9 fail", fail, 1'b0);
      rst_n = 1'b1;
      qual_wait("R2");

      // power good and threshold select
      dg = 1'b1; step(2);
      chk("R6 drain only", pgood, 1'b0);
      chk("R5 sel insertion", sel, 1'b1);
      gh = 1'b1; step(2);
      chk("R6 both good", pgood, 1'b1);
      chk("R5 sel normal", sel, 1'b0);
      dg = 1'b0; step(1);
      chk("R6 drop on drain fail", pgood, 1'b0);
      chk("R5 sel back", sel, 1'b1);
      dg = 1'b1; step(2);
      chk("R6 regain", pgood, 1'b1);
      gh = 1'b0; step(1);
      chk("R6 drop on gate fail", pgood, 1'b0);
      dg = 1'b0;

      // disqualifiers
      uv = 1'b1; step(2);
      chk("R1 uv", gate_on, 1'b0);
      uv = 1'b0; qual_wait("R2");
      ov = 1'b1; step(2);
      chk("R1 ov", gate_on, 1'b0);
      step(60);
      chk("R1 ov held", gate_on, 1'b0);
      ov = 1'b0; qual_wait("R2");
      mrh = 1'b1; step(2);
      chk("R1 man_rst", gate_on, 1'b0);
      step(60);
      chk("R1 man_rst held", gate_on, 1'b0);
      mrh = 1'b0; step((P/2)*D);
      mrh = 1'b1; step(1); mrh = 1'b0;
      qual_wait("R2 restart after man_rst");

      // directed filter corner: glitch under the longest window
      fcode = 2'd3; rcode = 2'd3;
      oc = 1'b1; step((win_ticks(2'd3)-1)*D); oc = 1'b0; step(3);
      chk("R3 code3 glitch ignored", gate_on, 1'b1);
      fcode = 2'd0;
      oc = 1'b1; step(2); oc = 1'b0; step(1);
      chk("R3 code0 immediate trip", gate_on, 1'b0);
      requal();

      // retry pause for every code
      for (int c = 0; c < 4; c++) begin
         rcode = 2'(c); fcode = 2'd0;
         oc = 1'b1;
         wait_fall(ok);
         oc = 1'b0;
         chk("R4 trip seen", ok, 1'b1);
         step((retry_ticks(2'(c))-1)*D);
         chk("R4 off during pause", gate_on, 1'b0);
         step(D + 2);
         chk("R4 on after pause", gate_on, 1'b1);
         requal();
      end

      // random filter trials
      rcode = 2'd3;
      for (int t = 0; t < 20; t++) begin
         logic [1:0] c;
         int w, len;
         bit trip;
         c = 2'($urandom_range(0, 3));
         w = win_ticks(c);
         if (w == 0) begin
            len = $urandom_range(1, 5); trip = 1'b1;
         end else if ($urandom_range(0, 1) == 0) begin
            len = $urandom_range(1, (w-1)*D > 0 ? (w-1)*D : 1);
            trip = ((w-1)*D == 0) ? 1'b0 : 1'b0;
         end else begin
            len = w*D + 1 + $urandom_range(0, 5); trip = 1'b1;
         end
         if (w != 0 && (w-1)*D == 0 && !trip) len = 0;
         fcode = c;
         if (len > 0) begin
            oc = 1'b1; step(len); oc = 1'b0;
         end
         step(3);
         chk("R3 random window", gate_on, !trip);
         if (trip) requal();
      end

      // lockout after consecutive trips
      fcode = 2'd0; rcode = 2'd0;
      oc = 1'b1; step(120);
      chk("R7 fail flag", fail, 1'b1);
      chk("R7 gate held off", gate_on, 1'b0);
      oc = 1'b0; step(400);
      chk("R7 lockout persists", fail, 1'b1);
      chk("R7 gate still off", gate_on, 1'b0);
      mrh = 1'b1; step(2);
      chk("R8 fail cleared", fail, 1'b0);
      mrh = 1'b0;
      qual_wait("R8 turn-on after lockout");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule